// File: doc/BRIEF.md
# Bit Logic Accumulator Unit

This block evaluates the bit-level logic of a small controller core. It holds one result bit (the running logic result), a scan state that decides whether the next logic instruction combines with that result or starts a new one, a pending value that collects OR-ed groups of AND terms, and a stack of up to six saved frames for bracketed sub-expressions. Each cycle with `opValid` high it takes one decoded instruction and a single operand bit read from an outside bit memory. The memory, fetch and decode all stay outside the block.

Logic instructions update the result. The write instructions (set, reset, assign) drive a write strobe and write data back to the bit memory in the same cycle. They leave the result unchanged and close the chain, so the next logic instruction loads a fresh value. A standalone OR-group instruction folds everything evaluated so far into the pending OR value, so that the AND terms written before it and after it are OR-ed together. Brackets save the outer context together with the way the group is to be joined, and a sticky error flag reports brackets that are nested too deep or closed when none is open.

Top module: `bitlogic_unit`

## Requirements
- R1: Instruction codes on `opCode` are 1 AND, 2 AND-NOT, 3 OR, 4 OR-NOT. AND and OR take the operand as it is, and the NOT forms take its inverse. Once the chain has started, the value taken is AND-ed or OR-ed into the result, which is visible on `rloOut` in the cycle after the instruction.
- R2: The first logic instruction after reset, or after a write instruction, loads the value taken from the operand as the new result. It discards the previous result and any pending OR value.
- R3: Code 5 (OR-group, no operand) folds the current result into the pending OR value. The next logic instruction starts a new AND term, and `rloOut` shows the pending value OR-ed with that term.
- R4: Code 6 (open-AND) and code 7 (open-OR) save the current context and start the group as a fresh chain, and `rloOut` reads 0 until the group's first logic instruction. Code 8 (close) joins the group result with the saved context using AND or OR as saved. If the bracket was opened at the start of a chain, the group result is loaded as the new result.
- R5: Brackets nest to six levels, and each close restores the matching outer context.
- R6: An open at six levels, or a close with no open bracket, sets `nestErr`. The flag stays set until reset, and `rloOut` and the nesting depth do not change.
- R7: Code 9 (set) writes 1 and code 10 (reset) writes 0 to the operand, but only when `rloOut` is 1. When `rloOut` is 0 neither one raises `wrEn`.
- R8: Code 11 (assign) always raises `wrEn` with `wrData` equal to `rloOut`.
- R9: Write instructions leave `rloOut` unchanged, and no other instruction ever raises `wrEn`.
- R10: A synchronous reset clears the result, the pending OR value, the stack and `nestErr`, and starts a fresh chain.
- R11: Cycles with `opValid` low, and the codes 0 and 12 to 15, change no state and raise no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Instruction present this cycle |
| opCode | input | 4 | Decoded instruction code |
| operandBit | input | 1 | Operand bit read from bit memory |
| rloOut | output | 1 | Current logic result |
| wrEn | output | 1 | Bit memory write strobe (combinational) |
| wrData | output | 1 | Bit memory write value |
| nestErr | output | 1 | Sticky bracket nesting error |

## Verification
The bench targets the chain restart after write instructions. A design that kept combining there would AND a fresh operand into a stale result. It checks OR-groups, where folding the wrong value loses the earlier AND term, and brackets opened at the start of a chain, where a design that combined with stale state would mask the group result. It drives the full six-level nest and one more, and a close with nothing open, to catch depth counters that wrap or corrupt the result. Random instruction streams compared against a reference model cover combinations the directed cases miss.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_AND     = 4'd1,
    OP_ANDN    = 4'd2,
    OP_OR      = 4'd3,
    OP_ORN     = 4'd4,
    OP_ORGRP   = 4'd5,
    OP_OPENAND = 4'd6,
    OP_OPENOR  = 4'd7,
    OP_CLOSE   = 4'd8,
    OP_SET     = 4'd9,
    OP_RESET   = 4'd10,
    OP_ASSIGN  = 4'd11
  } opcode_e;

  // How the next logic instruction treats the running result
  typedef enum logic [1:0] {
    SCAN_COMBINE  = 2'd0,
    SCAN_NEWTERM  = 2'd1,
    SCAN_NEWCHAIN = 2'd2
  } scan_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  logicEn;
    logic  negate;
    logic  orMode;
    scan_e scan;
    logic  foldEn;
    logic  pushEn;
    logic  pushIsOr;
    logic  popEn;
    logic  setReq;
    logic  resetReq;
    logic  assignReq;
  } strobe_t;

  // One saved bracket context
  typedef struct packed {
    logic  isOr;
    logic  rlo;
    logic  orAcc;
    scan_e scan;
  } frame_t;

endpackage

// File: rtl/bitlogic_ctrl.sv
module bitlogic_ctrl
  import bitlogic_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opValid,
  input  logic [3:0]    opCode,
  output strobe_t       strobe,
  output logic [PW-1:0] depthQ,
  output logic          nestErr
);

  localparam logic [PW-1:0] DEPTH_MAX = PW'(DEPTH);

  scan_e         scanQ, scanD;
  logic [PW-1:0] depthD;
  logic          errQ, errD;
  opcode_e       op;

  assign op = opcode_e'(opCode);

  always_comb begin
    strobe      = '0;
    strobe.scan = scanQ;
    scanD       = scanQ;
    depthD      = depthQ;
    errD        = errQ;
    if (opValid) begin
      case (op)
        OP_AND, OP_ANDN, OP_OR, OP_ORN: begin
          strobe.logicEn = 1'b1;
          strobe.negate  = (op == OP_ANDN) || (op == OP_ORN);
          strobe.orMode  = (op == OP_OR) || (op == OP_ORN);
          scanD          = SCAN_COMBINE;
        end
        OP_ORGRP: begin
          strobe.foldEn = 1'b1;
          scanD         = SCAN_NEWTERM;
        end
        OP_OPENAND, OP_OPENOR: begin
          if (depthQ == DEPTH_MAX) begin
            errD = 1'b1;
          end else begin
            strobe.pushEn   = 1'b1;
            strobe.pushIsOr = (op == OP_OPENOR);
            depthD          = depthQ + 1'b1;
            scanD           = SCAN_NEWCHAIN;
          end
        end
        OP_CLOSE: begin
          if (depthQ == '0) begin
            errD = 1'b1;
          end else begin
            strobe.popEn = 1'b1;
            depthD       = depthQ - 1'b1;
            scanD        = SCAN_COMBINE;
          end
        end
        OP_SET, OP_RESET, OP_ASSIGN: begin
          strobe.setReq    = (op == OP_SET);
          strobe.resetReq  = (op == OP_RESET);
          strobe.assignReq = (op == OP_ASSIGN);
          scanD            = SCAN_NEWCHAIN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanQ  <= SCAN_NEWCHAIN;
      depthQ <= '0;
      errQ   <= 1'b0;
    end else begin
      scanQ  <= scanD;
      depthQ <= depthD;
      errQ   <= errD;
    end
  end

  assign nestErr = errQ;

endmodule

// File: rtl/bitlogic_dp.sv
module bitlogic_dp
  import bitlogic_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobe,
  input  logic [PW-1:0] depthQ,
  input  logic          operandBit,
  output logic          rloOut,
  output logic          wrEn,
  output logic          wrData
);

  logic          rloQ, rloD;
  logic          orQ, orD;
  logic          effRlo;
  logic          sample;
  logic [PW-1:0] topIdx;
  frame_t        stackQ [DEPTH];
  frame_t        topFrame;
  frame_t        newFrame;

  assign effRlo   = rloQ | orQ;
  assign sample   = operandBit ^ strobe.negate;
  assign topIdx   = depthQ - 1'b1;
  assign newFrame = '{isOr: strobe.pushIsOr, rlo: rloQ, orAcc: orQ, scan: strobe.scan};

  // Stack slots, each written only when it is the push target
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stackQ[g] <= '0;
      end else if (strobe.pushEn && (depthQ == PW'(g))) begin
        stackQ[g] <= newFrame;
      end
    end
  end

  always_comb begin
    topFrame = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (topIdx == PW'(i)) topFrame = stackQ[i];
    end
  end

  always_comb begin
    rloD = rloQ;
    orD  = orQ;
    if (strobe.logicEn) begin
      case (strobe.scan)
        SCAN_COMBINE:  rloD = strobe.orMode ? (rloQ | sample) : (rloQ & sample);
        SCAN_NEWTERM:  rloD = sample;
        default: begin
          rloD = sample;
          orD  = 1'b0;
        end
      endcase
    end else if (strobe.foldEn) begin
      orD = effRlo;
    end else if (strobe.pushEn) begin
      rloD = 1'b0;
      orD  = 1'b0;
    end else if (strobe.popEn) begin
      case (topFrame.scan)
        SCAN_COMBINE: begin
          rloD = topFrame.isOr ? (topFrame.rlo | effRlo) : (topFrame.rlo & effRlo);
          orD  = topFrame.orAcc;
        end
        SCAN_NEWTERM: begin
          rloD = effRlo;
          orD  = topFrame.orAcc;
        end
        default: begin
          rloD = effRlo;
          orD  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rloQ <= 1'b0;
      orQ  <= 1'b0;
    end else begin
      rloQ <= rloD;
      orQ  <= orD;
    end
  end

  assign rloOut = effRlo;
  assign wrEn   = strobe.assignReq | ((strobe.setReq | strobe.resetReq) & effRlo);
  assign wrData = strobe.assignReq ? effRlo : strobe.setReq;

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       operandBit,
  output logic       rloOut,
  output logic       wrEn,
  output logic       wrData,
  output logic       nestErr
);

  localparam int PW = $clog2(DEPTH + 1);

  strobe_t       strobe;
  logic [PW-1:0] depthQ;

  bitlogic_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe),
    .depthQ  (depthQ),
    .nestErr (nestErr)
  );

  bitlogic_dp #(.DEPTH(DEPTH), .PW(PW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .depthQ     (depthQ),
    .operandBit (operandBit),
    .rloOut     (rloOut),
    .wrEn       (wrEn),
    .wrData     (wrData)
  );

endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk
  import bitlogic_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic       rloOut,
  input logic       wrEn,
  input logic       wrData,
  input logic       nestErr
);

  logic isWrite;
  assign isWrite = opValid && (opCode == OP_SET || opCode == OP_RESET || opCode == OP_ASSIGN);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    nestErr |=> nestErr);

  assert_err_keeps_rlo_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nestErr) |-> $stable(rloOut));

  assert_set_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_SET) |-> (wrEn == rloOut) && (!wrEn || wrData));

  assert_reset_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_RESET) |-> (wrEn == rloOut) && (!wrEn || !wrData));

  assert_assign_R8: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_ASSIGN) |-> wrEn && (wrData == rloOut));

  assert_write_keeps_rlo_R9: assert property (@(posedge clk) disable iff (rst)
    isWrite |=> $stable(rloOut));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (rst)
    !isWrite |-> !wrEn);

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (!nestErr && !rloOut));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> ($stable(rloOut) && $stable(nestErr)));

endmodule

bind bitlogic_unit bitlogic_unit_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .opValid (opValid),
  .opCode  (opCode),
  .rloOut  (rloOut),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .nestErr (nestErr)
);

// File: tb/sim_bitlogic_unit.sv
module sim_bitlogic_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic       operandBit = 1'b0;
  logic       rloOut, wrEn, wrData, nestErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitlogic_unit u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .operandBit(operandBit), .rloOut(rloOut), .wrEn(wrEn),
    .wrData(wrData), .nestErr(nestErr)
  );

  // Reference model state
  bit mRlo, mOr, mErr;
  int mScan;   // 0 combine, 1 new term, 2 new chain
  int mDepth;
  bit sIsOr [6];
  bit sRlo  [6];
  bit sOr   [6];
  int sScan [6];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mRlo = 0; mOr = 0; mErr = 0; mScan = 2; mDepth = 0;
  endtask

  task automatic modelStep(input logic v, input logic [3:0] op, input logic b,
                           output bit expWe, output bit expWd);
    bit cur, val, res;
    cur = mRlo | mOr;
    expWe = 0; expWd = 0;
    if (!v) return;
    if (op >= 4'd1 && op <= 4'd4) begin
      val = (op == 4'd2 || op == 4'd4) ? ~b : b;
      if (mScan == 2) begin mRlo = val; mOr = 0; end
      else if (mScan == 1) mRlo = val;
      else if (op == 4'd3 || op == 4'd4) mRlo = mRlo | val;
      else mRlo = mRlo & val;
      mScan = 0;
    end else if (op == 4'd5) begin
      mOr = cur; mScan = 1;
    end else if (op == 4'd6 || op == 4'd7) begin
      if (mDepth == 6) mErr = 1;
      else begin
        sIsOr[mDepth] = (op == 4'd7); sRlo[mDepth] = mRlo;
        sOr[mDepth] = mOr; sScan[mDepth] = mScan;
        mDepth++; mRlo = 0; mOr = 0; mScan = 2;
      end
    end else if (op == 4'd8) begin
      if (mDepth == 0) mErr = 1;
      else begin
        mDepth--;
        res = cur;
        if (sScan[mDepth] == 2) begin mRlo = res; mOr = 0; end
        else if (sScan[mDepth] == 1) begin mRlo = res; mOr = sOr[mDepth]; end
        else begin
          mRlo = sIsOr[mDepth] ? (sRlo[mDepth] | res) : (sRlo[mDepth] & res);
          mOr = sOr[mDepth];
        end
        mScan = 0;
      end
    end else if (op >= 4'd9 && op <= 4'd11) begin
      if (op == 4'd11) begin expWe = 1; expWd = cur; end
      else if (cur) begin expWe = 1; expWd = (op == 4'd9); end
      mScan = 2;
    end
  endtask

  // One instruction: write outputs checked before the edge, state after it
  task automatic issue(input logic v, input logic [3:0] op, input logic b, input string req);
    bit ew, ed;
    @(negedge clk);
    opValid = v; opCode = op; operandBit = b;
    modelStep(v, op, b, ew, ed);
    #1;
    check(wrEn == ew, {req, " wrEn"}, wrEn, ew);
    if (ew) check(wrData == ed, {req, " wrData"}, wrData, ed);
    @(posedge clk); #1;
    opValid = 0;
    check(rloOut == (mRlo | mOr), {req, " rlo"}, rloOut, mRlo | mOr);
    check(nestErr == mErr, {req, " nestErr"}, nestErr, mErr);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; opValid = 0;
    @(posedge clk); #1;
    rst = 0;
    modelReset();
    check(rloOut == 0, "R10 reset rlo", rloOut, 0);
    check(nestErr == 0, "R10 reset nestErr", nestErr, 0);
  endtask

  // {op, operand, expWrEn, expWrData, expRlo, requirement number}
  localparam int NVEC = 21;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 first load
    {4'd2,  1'b1, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 and-not
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 or-not
    {4'd11, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 assign 1
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fresh load
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 set blocked
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fresh or-not
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 or
    {4'd10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 reset writes 0
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd1},  // R1
    {4'd5,  1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 fold
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 new term 0, pending 1
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    {4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 set writes 1
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 pending cleared
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    {4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 fold 0
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    {4'd11, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}   // R8 assign 0
  };

  initial begin
    modelReset();
    doReset();

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vec%0d", e[3:0], i);
      @(negedge clk);
      opValid = 1; opCode = e[11:8]; operandBit = e[7];
      #1;
      check(wrEn == e[6], {tag, " wrEn"}, wrEn, e[6]);
      if (e[6]) check(wrData == e[5], {tag, " wrData"}, wrData, e[5]);
      @(posedge clk); #1;
      opValid = 0;
      check(rloOut == e[4], {tag, " rlo"}, rloOut, e[4]);
    end

    // R4 AND bracket: 1 & (0 | 1) = 1
    doReset();
    issue(1, 4'd1, 1, "R4");
    issue(1, 4'd6, 0, "R4");
    check(rloOut == 0, "R4 open reads 0", rloOut, 0);
    issue(1, 4'd1, 0, "R4");
    issue(1, 4'd3, 1, "R4");
    issue(1, 4'd8, 0, "R4");
    check(rloOut == 1, "R4 and-bracket", rloOut, 1);
    issue(1, 4'd6, 0, "R4");
    issue(1, 4'd1, 0, "R4");
    issue(1, 4'd8, 0, "R4");
    check(rloOut == 0, "R4 and-bracket 0", rloOut, 0);
    // R4 OR bracket at chain start loads the group result
    issue(1, 4'd11, 0, "R4");
    issue(1, 4'd7, 0, "R4");
    issue(1, 4'd1, 1, "R4");
    issue(1, 4'd8, 0, "R4");
    check(rloOut == 1, "R4 fresh bracket load", rloOut, 1);
    issue(1, 4'd11, 0, "R4");
    issue(1, 4'd1, 0, "R4");
    issue(1, 4'd7, 0, "R4");
    issue(1, 4'd1, 1, "R4");
    issue(1, 4'd8, 0, "R4");
    check(rloOut == 1, "R4 or-bracket", rloOut, 1);

    // R5 six levels, R6 seventh
    doReset();
    issue(1, 4'd1, 1, "R5");
    for (int k = 0; k < 6; k++) issue(1, 4'd6, 0, "R5");
    check(nestErr == 0, "R5 six levels no error", nestErr, 0);
    issue(1, 4'd1, 1, "R5");
    for (int k = 0; k < 6; k++) issue(1, 4'd8, 0, "R5");
    check(rloOut == 1, "R5 unwound", rloOut, 1);
    check(nestErr == 0, "R5 unwound no error", nestErr, 0);
    for (int k = 0; k < 6; k++) issue(1, 4'd7, 0, "R6");
    issue(1, 4'd1, 1, "R6");
    issue(1, 4'd6, 0, "R6");
    check(nestErr == 1, "R6 overflow flag", nestErr, 1);
    check(rloOut == 1, "R6 overflow keeps rlo", rloOut, 1);
    issue(1, 4'd1, 0, "R6");
    check(nestErr == 1, "R6 sticky", nestErr, 1);
    doReset();
    issue(1, 4'd1, 1, "R6");
    issue(1, 4'd8, 0, "R6");
    check(nestErr == 1, "R6 underflow flag", nestErr, 1);
    check(rloOut == 1, "R6 underflow keeps rlo", rloOut, 1);

    // R11 idle and unused codes
    doReset();
    issue(1, 4'd1, 1, "R11");
    issue(0, 4'd1, 0, "R11");
    check(rloOut == 1, "R11 opValid low ignored", rloOut, 1);
    issue(1, 4'd15, 0, "R11");
    check(rloOut == 1, "R11 unused code ignored", rloOut, 1);
    issue(1, 4'd0, 0, "R11");
    issue(1, 4'd9, 0, "R11");

    // Random streams against the model (R1 R2 R3 R4 R7 R8 R9)
    for (int r = 0; r < 3000; r++) begin
      logic [3:0] op;
      if (r % 250 == 0) doReset();
      op = 4'($urandom_range(1, 11));
      issue(($urandom_range(0, 9) != 0), op, 1'($urandom_range(0, 1)), "R9 random");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule